// File: doc/BRIEF.md
# Packed Real/Complex Multiply-Accumulate Unit

This datapath unit performs one packed arithmetic operation per issued instruction on 64-bit operand words in Q15 fixed point. In real mode each word carries four independent signed 16-bit subwords. The unit forms four products and adds each one to the matching accumulator subword, to zero, or to nothing. In complex mode each 32-bit lane carries one complex value: the real part in the lower half and the imaginary part in the upper half. The unit then forms two complex products, with or without accumulation, or a radix-2 butterfly that yields two packed result words.

Every subword lane owns a pair of 16x16 multipliers that compute the direct products a_lo*b_lo and a_hi*b_hi, which real mode uses alone. Two cross-product multipliers per lane join in for complex mode, and a gated second operand on each lane adder turns the real sums into the complex real and imaginary sums. Products are kept at full precision, rounded half-up to Q15 and then saturated. Every addition after rounding saturates to the signed 16-bit limits instead of wrapping.

The result is registered, so each issue produces exactly one result on the following edge. A three-state output sequencer tracks the outputs. ST_IDLE holds from reset until the first issue. ST_OUT holds while a fresh result is presented. ST_KEEP holds the last result with the valid flag low. The transitions are: ST_IDLE→ST_OUT on issue; ST_OUT→ST_OUT on issue; ST_OUT→ST_KEEP with no issue; ST_KEEP→ST_OUT on issue; ST_KEEP→ST_KEEP with no issue; ST_IDLE→ST_IDLE with no issue.

Top module: `cmac_simd_unit`

## Requirements
- R1: While rst_n is low, rslt_valid, rslt_main and rslt_aux are all zero, whatever the inputs are.
- R2: When issue_valid is high at a rising edge, rslt_valid is high after that same edge and the result words hold that instruction's results. Issues on back-to-back edges give back-to-back results.
- R3: Opcode 000 (real multiply) returns, for each subword i at bits [16i+15:16i], sat(rnd(a_i*b_i)). Here rnd(x) = floor((x + 16384) / 32768) and sat clamps to [-32768, 32767]. acc_word has no effect.
- R4: Opcode 001 (real multiply-accumulate) returns, for each subword, sat(rnd(a_i*b_i) + acc_i).
- R5: Opcode 010 (real multiply-accumulate from zero) returns sat(rnd(a_i*b_i)) for each subword and ignores acc_word.
- R6: In complex mode, lane k has its real part at bits [32k+15:32k] and its imaginary part at bits [32k+31:32k+16]. Opcode 100 returns re = sat(rnd(ar*br − ai*bi)) and im = sat(rnd(ar*bi + ai*br)), and acc_word has no effect.
- R7: Opcode 101 adds the accumulator lane's real and imaginary parts to the rounded sums before saturation. Opcode 110 returns the same as opcode 100.
- R8: Opcode 111 (butterfly) computes t = the opcode 100 result of opnd_b times opnd_w for each lane. It returns rslt_main = sat(a + t) and rslt_aux = sat(a − t), part by part, and acc_word has no effect.
- R9: For every opcode other than 111, rslt_aux is zero.
- R10: Opcode 011 is reserved. It returns zero on both result words, and rslt_valid still rises.
- R11: In real mode, −32768 × −32768 yields 32767. In complex mode, with all four parts at −32768, the lane yields re = 0 and im = 32767.
- R12: An edge without issue_valid drops rslt_valid after that edge and leaves both result words unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| issue_valid | input | 1 | Instruction issued this cycle |
| opcode | input | 3 | Operation select (bit 2 = complex mode) |
| opnd_a | input | 64 | First source word (butterfly: upper input a) |
| opnd_b | input | 64 | Second source word |
| opnd_w | input | 64 | Third source word, used only as the butterfly twiddle factor |
| acc_word | input | 64 | Accumulator subwords or lanes |
| rslt_valid | output | 1 | Result words carry a fresh result |
| rslt_main | output | 64 | Primary packed result (butterfly: a + t) |
| rslt_aux | output | 64 | Butterfly difference a − t, zero otherwise |

## Verification
Every result is due on the first rising edge after its issue edge, so the bench drives on falling edges and samples 2 ns after each rising edge. The driver pushes each instruction's expected words into a scoreboard queue at issue. The monitor pops exactly one entry on each sampled edge where rslt_valid is high, and a non-empty queue without a valid flag counts as a latency miss. On sampled edges without a result, the monitor checks that the two words still equal the last result.

// File: rtl/cmac_pkg.sv
package cmac_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_OUT  = 2'd1,
        ST_KEEP = 2'd2
    } out_state_e;

    typedef struct packed {
        logic cplx;
        logic use_acc;
        logic bfly;
        logic rsvd;
    } cmac_ctrl_t;

    localparam logic [2:0] OPC_BFLY = 3'b111;
    localparam logic [2:0] OPC_RSVD = 3'b011;

    function automatic cmac_ctrl_t decode_op(input logic [2:0] opc);
        cmac_ctrl_t c;
        c.cplx    = opc[2];
        c.use_acc = (opc[1:0] == 2'b01);
        c.bfly    = (opc == OPC_BFLY);
        c.rsvd    = (opc == OPC_RSVD);
        return c;
    endfunction

endpackage

// File: rtl/cmac_mul16.sv
module cmac_mul16 #(
    parameter int SUB_W = 16
) (
    input  logic signed [SUB_W-1:0]   x,
    input  logic signed [SUB_W-1:0]   y,
    output logic signed [2*SUB_W-1:0] p
);
    assign p = x * y;
endmodule

// File: rtl/cmac_lane.sv
module cmac_lane #(
    parameter int SUB_W = 16
) (
    input  logic [2*SUB_W-1:0]      x_lane,
    input  logic [2*SUB_W-1:0]      y_lane,
    input  logic                    cplx,
    output logic signed [2*SUB_W:0] term_lo,
    output logic signed [2*SUB_W:0] term_hi
);
    localparam int PROD_W = 2 * SUB_W;
    localparam int SUM_W  = PROD_W + 1;
    localparam int FRAC   = SUB_W - 1;
    localparam int NMUL   = 4;
    localparam logic [SUM_W-1:0] BIAS =
        {{(SUM_W-FRAC){1'b0}}, 1'b1, {(FRAC-1){1'b0}}};

    logic signed [SUB_W-1:0]  mx [NMUL];
    logic signed [SUB_W-1:0]  my [NMUL];
    logic signed [PROD_W-1:0] pr [NMUL];
    logic signed [SUM_W-1:0]  px [NMUL];

    // 0: lo*lo, 1: hi*hi (direct, real mode), 2: lo*hi, 3: hi*lo (cross)
    always_comb begin
        mx[0] = x_lane[SUB_W-1:0];       my[0] = y_lane[SUB_W-1:0];
        mx[1] = x_lane[2*SUB_W-1:SUB_W]; my[1] = y_lane[2*SUB_W-1:SUB_W];
        mx[2] = x_lane[SUB_W-1:0];       my[2] = y_lane[2*SUB_W-1:SUB_W];
        mx[3] = x_lane[2*SUB_W-1:SUB_W]; my[3] = y_lane[SUB_W-1:0];
    end

    genvar g;
    generate
        for (g = 0; g < NMUL; g++) begin : g_mul
            cmac_mul16 #(.SUB_W(SUB_W)) u_mul (
                .x(mx[g]),
                .y(my[g]),
                .p(pr[g])
            );
            assign px[g] = {pr[g][PROD_W-1], pr[g]};
        end
    endgenerate

    logic signed [SUM_W-1:0] lo_rhs, hi_lhs, hi_rhs;
    logic signed [SUM_W-1:0] sum_lo, sum_hi, bias_lo, bias_hi;

    // one adder per subword; complex mode opens its second operand
    always_comb begin
        lo_rhs  = cplx ? -px[1] : '0;
        hi_lhs  = cplx ? px[2] : px[1];
        hi_rhs  = cplx ? px[3] : '0;
        sum_lo  = px[0] + lo_rhs;
        sum_hi  = hi_lhs + hi_rhs;
        bias_lo = sum_lo + BIAS;
        bias_hi = sum_hi + BIAS;
    end

    assign term_lo = bias_lo >>> FRAC;
    assign term_hi = bias_hi >>> FRAC;

endmodule

// File: rtl/cmac_sat_add.sv
module cmac_sat_add #(
    parameter int SUB_W = 16
) (
    input  logic signed [2*SUB_W:0] term,
    input  logic [SUB_W-1:0]        addend,
    input  logic [SUB_W-1:0]        a_sub,
    input  logic                    bfly,
    output logic [SUB_W-1:0]        r_main,
    output logic [SUB_W-1:0]        r_aux
);
    localparam int TERM_W = 2 * SUB_W + 1;
    localparam int WIDE_W = TERM_W + 1;
    localparam logic signed [WIDE_W-1:0] MAXV =
        {{(WIDE_W-SUB_W+1){1'b0}}, {(SUB_W-1){1'b1}}};
    localparam logic signed [WIDE_W-1:0] MINV =
        {{(WIDE_W-SUB_W+1){1'b1}}, {(SUB_W-1){1'b0}}};

    function automatic logic [SUB_W-1:0] clip(input logic signed [WIDE_W-1:0] v);
        if (v > MAXV)      clip = MAXV[SUB_W-1:0];
        else if (v < MINV) clip = MINV[SUB_W-1:0];
        else               clip = v[SUB_W-1:0];
    endfunction

    logic signed [WIDE_W-1:0] term_x, add_x, a_x, t_x;
    logic [SUB_W-1:0]         t_sat;
    logic signed [WIDE_W-1:0] lhs, rhs, s_main, s_aux;

    always_comb begin
        term_x = {{(WIDE_W-TERM_W){term[TERM_W-1]}}, term};
        add_x  = {{(WIDE_W-SUB_W){addend[SUB_W-1]}}, addend};
        a_x    = {{(WIDE_W-SUB_W){a_sub[SUB_W-1]}}, a_sub};
        t_sat  = clip(term_x);
        t_x    = {{(WIDE_W-SUB_W){t_sat[SUB_W-1]}}, t_sat};
        lhs    = bfly ? t_x : term_x;
        rhs    = bfly ? a_x : add_x;
        s_main = lhs + rhs;
        s_aux  = a_x - t_x;
        r_main = clip(s_main);
        r_aux  = bfly ? clip(s_aux) : '0;
    end

endmodule

// File: rtl/cmac_simd_unit.sv
module cmac_simd_unit
    import cmac_pkg::*;
#(
    parameter int SUB_W  = 16,
    parameter int CLANES = 2
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       issue_valid,
    input  logic [2:0]                 opcode,
    input  logic [2*SUB_W*CLANES-1:0]  opnd_a,
    input  logic [2*SUB_W*CLANES-1:0]  opnd_b,
    input  logic [2*SUB_W*CLANES-1:0]  opnd_w,
    input  logic [2*SUB_W*CLANES-1:0]  acc_word,
    output logic                       rslt_valid,
    output logic [2*SUB_W*CLANES-1:0]  rslt_main,
    output logic [2*SUB_W*CLANES-1:0]  rslt_aux
);
    localparam int NSUB   = 2 * CLANES;
    localparam int LANE_W = 2 * SUB_W;
    localparam int WORD_W = SUB_W * NSUB;
    localparam int TERM_W = 2 * SUB_W + 1;

    cmac_ctrl_t ctrl;
    assign ctrl = decode_op(opcode);

    logic signed [TERM_W-1:0] term_w [NSUB];
    logic [WORD_W-1:0]        nxt_main, nxt_aux;

    genvar k, s;
    generate
        for (k = 0; k < CLANES; k++) begin : g_lane
            logic [LANE_W-1:0] x_l, y_l;
            assign x_l = ctrl.bfly ? opnd_b[k*LANE_W +: LANE_W] : opnd_a[k*LANE_W +: LANE_W];
            assign y_l = ctrl.bfly ? opnd_w[k*LANE_W +: LANE_W] : opnd_b[k*LANE_W +: LANE_W];
            cmac_lane #(.SUB_W(SUB_W)) u_lane (
                .x_lane (x_l),
                .y_lane (y_l),
                .cplx   (ctrl.cplx),
                .term_lo(term_w[2*k]),
                .term_hi(term_w[2*k+1])
            );
        end
        for (s = 0; s < NSUB; s++) begin : g_sub
            logic [SUB_W-1:0] addend_s;
            assign addend_s = ctrl.use_acc ? acc_word[s*SUB_W +: SUB_W] : '0;
            cmac_sat_add #(.SUB_W(SUB_W)) u_add (
                .term  (term_w[s]),
                .addend(addend_s),
                .a_sub (opnd_a[s*SUB_W +: SUB_W]),
                .bfly  (ctrl.bfly),
                .r_main(nxt_main[s*SUB_W +: SUB_W]),
                .r_aux (nxt_aux[s*SUB_W +: SUB_W])
            );
        end
    endgenerate

    // output sequencer
    out_state_e state_q, state_d;

    always_comb begin
        unique case (state_q)
            ST_IDLE: state_d = issue_valid ? ST_OUT : ST_IDLE;
            ST_OUT:  state_d = issue_valid ? ST_OUT : ST_KEEP;
            ST_KEEP: state_d = issue_valid ? ST_OUT : ST_KEEP;
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    logic [WORD_W-1:0] main_q, aux_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            main_q <= '0;
            aux_q  <= '0;
        end else if (issue_valid) begin
            main_q <= ctrl.rsvd ? '0 : nxt_main;
            aux_q  <= ctrl.rsvd ? '0 : nxt_aux;
        end
    end

    assign rslt_valid = (state_q == ST_OUT);
    assign rslt_main  = main_q;
    assign rslt_aux   = aux_q;

    AST_ONE_RESULT_PER_ISSUE: assert property (@(posedge clk) disable iff (!rst_n)
        issue_valid |=> rslt_valid); // R2
    AST_NO_SPURIOUS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        !issue_valid |=> !rslt_valid); // R12
    AST_HOLD_WHEN_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !issue_valid |=> ($stable(rslt_main) && $stable(rslt_aux))); // R12
    AST_AUX_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (issue_valid && opcode != OPC_BFLY) |=> (rslt_aux == '0)); // R9
    AST_RESERVED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (issue_valid && opcode == OPC_RSVD) |=> (rslt_main == '0 && rslt_valid)); // R10

endmodule

// File: tb/cmac_simd_unit_test.sv
module cmac_simd_unit_test;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        issue_valid;
    logic [2:0]  opcode;
    logic [63:0] opnd_a, opnd_b, opnd_w, acc_word;
    logic        rslt_valid;
    logic [63:0] rslt_main, rslt_aux;

    always #4 clk = ~clk;   // 125 MHz

    cmac_simd_unit uut (
        .clk(clk), .rst_n(rst_n), .issue_valid(issue_valid), .opcode(opcode),
        .opnd_a(opnd_a), .opnd_b(opnd_b), .opnd_w(opnd_w), .acc_word(acc_word),
        .rslt_valid(rslt_valid), .rslt_main(rslt_main), .rslt_aux(rslt_aux)
    );

    typedef struct {
        logic [63:0] e_main;
        logic [63:0] e_aux;
        string       tag;
    } exp_t;

    exp_t        sb [$];
    int          n_chk  = 0;
    int          n_fail = 0;
    bit          done   = 0;
    logic [63:0] last_main, last_aux;
    bit          have_last = 0;

    function automatic longint sx(input logic [15:0] v);
        return longint'($signed(v));
    endfunction
    function automatic longint sat(input longint v);
        if (v > 32767)  return 32767;
        if (v < -32768) return -32768;
        return v;
    endfunction
    function automatic longint rq(input longint v);
        return (v + 16384) >>> 15;
    endfunction

    function automatic void model(input logic [2:0] op, input logic [63:0] a, b, w, acc,
                                  output logic [63:0] m, output logic [63:0] x);
        m = '0; x = '0;
        if (op == 3'b011) return;
        if (!op[2]) begin
            for (int i = 0; i < 4; i++) begin
                longint r;
                r = rq(sx(a[16*i +: 16]) * sx(b[16*i +: 16]));
                if (op == 3'b001) r = r + sx(acc[16*i +: 16]);
                m[16*i +: 16] = 16'(sat(r));
            end
        end else begin
            for (int k = 0; k < 2; k++) begin
                logic [31:0] xl, yl;
                longint xr, xi, yr, yi, re, im;
                xl = (op == 3'b111) ? b[32*k +: 32] : a[32*k +: 32];
                yl = (op == 3'b111) ? w[32*k +: 32] : b[32*k +: 32];
                xr = sx(xl[15:0]); xi = sx(xl[31:16]);
                yr = sx(yl[15:0]); yi = sx(yl[31:16]);
                re = rq(xr * yr - xi * yi);
                im = rq(xr * yi + xi * yr);
                if (op == 3'b111) begin
                    longint ar, ai;
                    re = sat(re); im = sat(im);
                    ar = sx(a[32*k +: 16]); ai = sx(a[32*k+16 +: 16]);
                    m[32*k +: 16]    = 16'(sat(ar + re));
                    m[32*k+16 +: 16] = 16'(sat(ai + im));
                    x[32*k +: 16]    = 16'(sat(ar - re));
                    x[32*k+16 +: 16] = 16'(sat(ai - im));
                end else begin
                    if (op == 3'b101) begin
                        re = re + sx(acc[32*k +: 16]);
                        im = im + sx(acc[32*k+16 +: 16]);
                    end
                    m[32*k +: 16]    = 16'(sat(re));
                    m[32*k+16 +: 16] = 16'(sat(im));
                end
            end
        end
    endfunction

    task automatic issue_exp(input logic [2:0] op, input logic [63:0] a, b, w, acc,
                             input logic [63:0] em, ex, input string tag);
        exp_t e;
        @(negedge clk);
        issue_valid = 1'b1; opcode = op;
        opnd_a = a; opnd_b = b; opnd_w = w; acc_word = acc;
        e.e_main = em; e.e_aux = ex; e.tag = tag;
        sb.push_back(e);
    endtask

    task automatic issue(input logic [2:0] op, input logic [63:0] a, b, w, acc, input string tag);
        logic [63:0] em, ex;
        model(op, a, b, w, acc, em, ex);
        issue_exp(op, a, b, w, acc, em, ex, tag);
    endtask

    task automatic quiet(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            issue_valid = 1'b0;
            opnd_a = {$urandom, $urandom}; acc_word = {$urandom, $urandom};
        end
    endtask

    task automatic check(input bit ok, input string tag, input logic [63:0] act, exp_v);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual %h expected %h", tag, act, exp_v);
        end
    endtask

    // monitor: one sample 2 ns after each rising edge
    initial begin
        forever begin
            @(posedge clk); #2;
            if (rst_n) begin
                if (rslt_valid) begin
                    if (sb.size() == 0) begin
                        check(1'b0, "R2 result without issue", {63'd0, rslt_valid}, 64'd0);
                    end else begin
                        exp_t e;
                        e = sb.pop_front();
                        check(rslt_main == e.e_main, {e.tag, " main"}, rslt_main, e.e_main);
                        check(rslt_aux == e.e_aux, {e.tag, " aux"}, rslt_aux, e.e_aux);
                    end
                    last_main = rslt_main; last_aux = rslt_aux; have_last = 1;
                end else begin
                    if (sb.size() != 0) begin
                        sb.delete();
                        check(1'b0, "R2 result missing", {63'd0, rslt_valid}, 64'd1);
                    end
                    if (have_last) begin
                        check(rslt_main == last_main, "R12 hold main", rslt_main, last_main);
                        check(rslt_aux == last_aux, "R12 hold aux", rslt_aux, last_aux);
                    end
                end
            end
        end
    end

    initial begin
        #(8 * 100000);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog expired actual busy expected done");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; issue_valid = 1'b1; opcode = 3'b001;
        opnd_a = 64'h7FFF_1234_8000_0001; opnd_b = 64'h7FFF_7FFF_8000_0001;
        opnd_w = '0; acc_word = 64'h1111_2222_3333_4444;
        repeat (3) @(negedge clk);
        check(rslt_valid == 1'b0, "R1 valid in reset", {63'd0, rslt_valid}, 64'd0);
        check(rslt_main == '0, "R1 main in reset", rslt_main, 64'd0);
        check(rslt_aux == '0, "R1 aux in reset", rslt_aux, 64'd0);
        issue_valid = 1'b0;
        @(negedge clk); rst_n = 1'b1;
        @(negedge clk);
        check(rslt_valid == 1'b0, "R1 valid after release", {63'd0, rslt_valid}, 64'd0);

        // R11 corners and R3 ignoring acc
        issue_exp(3'b000, {4{16'h8000}}, {4{16'h8000}}, '0, 64'h1234_5678_9ABC_DEF0,
                  {4{16'h7FFF}}, '0, "R11 R3 real min*min");
        issue_exp(3'b100, {4{16'h8000}}, {4{16'h8000}}, '0, 64'h1234_5678_9ABC_DEF0,
                  {2{32'h7FFF_0000}}, '0, "R11 R6 complex min*min");
        // R3 rounding: 0.5*1 lsb rounds up, 0.5*-1 lsb rounds to zero
        issue_exp(3'b000, {4{16'h4000}}, 64'h0001_FFFF_0001_FFFF, '0, '1,
                  64'h0001_0000_0001_0000, '0, "R3 rounding");
        // R4 saturation both directions
        issue_exp(3'b001, {4{16'h7FFF}}, {4{16'h7FFF}}, '0, {4{16'h7FFF}},
                  {4{16'h7FFF}}, '0, "R4 positive saturation");
        issue_exp(3'b001, {4{16'h8000}}, {4{16'h7FFF}}, '0, {4{16'h8000}},
                  {4{16'h8000}}, '0, "R4 negative saturation");
        issue(3'b001, 64'h0100_F000_2000_0800, 64'h4000_4000_C000_7FFF, '0,
              64'h0010_FFF0_0100_8001, "R4 mixed");
        issue(3'b010, 64'h0100_F000_2000_0800, 64'h4000_4000_C000_7FFF, '0,
              64'h7FFF_7FFF_7FFF_7FFF, "R5 acc ignored");
        issue(3'b101, 64'h2000_4000_C000_1000, 64'h4000_2000_3000_E000, '0,
              64'h0100_FF00_7000_9000, "R7 cmac");
        issue(3'b110, 64'h2000_4000_C000_1000, 64'h4000_2000_3000_E000, '0,
              64'h0100_FF00_7000_9000, "R7 cmacz");
        issue(3'b111, 64'h7FFF_8000_1000_2000, 64'h4000_4000_7FFF_8000,
              64'h7FFF_7FFF_4000_C000, 64'hFFFF_FFFF_FFFF_FFFF, "R8 butterfly sat");
        issue_exp(3'b011, '1, '1, '1, '1, '0, '0, "R10 reserved");
        quiet(2);
        issue_exp(3'b111, 64'h0000_1000_0000_1000, 64'h0000_4000_0000_4000,
                  64'h0000_4000_0000_4000, '0, 64'h0000_3000_0000_3000,
                  64'h0000_F000_0000_F000, "R8 butterfly exact");
        quiet(1);

        // random traffic over all opcodes with gaps
        for (int n = 0; n < 600; n++) begin
            logic [2:0]  op;
            logic [63:0] a, b, w, c;
            op = 3'($urandom_range(0, 7));
            a = {$urandom, $urandom}; b = {$urandom, $urandom};
            w = {$urandom, $urandom}; c = {$urandom, $urandom};
            if ($urandom_range(0, 7) == 0) a[15:0] = 16'h8000;
            if ($urandom_range(0, 7) == 0) b[15:0] = 16'h8000;
            case (op)
                3'b000: issue(op, a, b, w, c, "R3 random");
                3'b001: issue(op, a, b, w, c, "R4 random");
                3'b010: issue(op, a, b, w, c, "R5 random");
                3'b011: issue(op, a, b, w, c, "R10 random");
                3'b100: issue(op, a, b, w, c, "R6 random");
                3'b111: issue(op, a, b, w, c, "R8 random");
                default: issue(op, a, b, w, c, "R7 R9 random");
            endcase
            if ($urandom_range(0, 3) == 0) quiet($urandom_range(1, 3));
        end
        quiet(4);
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

endmodule